// File: doc/BRIEF.md
# Packed Lane Saturating Adder/Subtractor

This block performs add and subtract on a 32-bit word that is split into independent lanes. A 3-bit operation code picks the lane shape, the direction and whether the lane overflows by wrapping or by clamping. In halfword shape each word holds two signed 16-bit numbers. In byte shape each word holds four unsigned 8-bit numbers. Carries and borrows never pass from one lane into the next.

The operation is taken in on a cycle where `opValid` is high. The lane results and one overflow flag per lane come out of a register one clock later. Each accepted operation ORs its lane flags into a sticky status vector. The status vector keeps those bits until a clear strobe with a bit mask removes them. Software can use it to learn that some lane clamped or wrapped over a long run of operations.

Top module: `simd_sat_alu`

## Requirements
- R1: After reset (`rstN` low), `result`, `laneFlags`, `stickyFlags` and `resultValid` are all zero.
- R2: `opCode` bit 2 selects byte shape (1) or halfword shape (0), bit 1 selects subtract (1) or add (0), and bit 0 selects clamping (1) or wrapping (0). This gives eight operations, 3'b000 to 3'b111.
- R3: In halfword shape, bits 31:16 and bits 15:0 are computed separately as 16-bit two's complement add or subtract (srcA lane minus srcB lane). In wrapping mode each half is its exact result modulo 2^16, with no carry passing between the halves.
- R4: In halfword shape, `laneFlags[0]` (low half) and `laneFlags[1]` (high half) are set when the exact signed result of that half lies outside -32768..32767, and `laneFlags[3:2]` are zero.
- R5: In halfword clamping mode, a half whose exact result is above 32767 gives 16'h7FFF, and one below -32768 gives 16'h8000. The flag of that half is set.
- R6: In byte shape, byte i (bits 8i+7:8i) is the unsigned add or subtract of the matching bytes. In wrapping mode it is taken modulo 256, and `laneFlags[i]` is set on carry out (add) or borrow (subtract).
- R7: In byte clamping mode, an add that exceeds 255 gives 8'hFF and a subtract that goes below 0 gives 8'h00. `laneFlags[i]` is set for that byte.
- R8: `result` and `laneFlags` update on the clock edge that samples `opValid` high, and `resultValid` is high for the one cycle that follows. With `opValid` low, `result` and `laneFlags` hold their values and `resultValid` is low.
- R9: On each accepted operation, `stickyFlags` ORs in that operation's lane flags. A bit is cleared only on a cycle with `clrEn` high and the matching `clrMask` bit set. If a new flag and a clear hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Accept the operation on this cycle |
| opCode | input | 3 | Operation: {byte shape, subtract, clamp} |
| srcA | input | 32 | First operand word |
| srcB | input | 32 | Second operand word (subtrahend) |
| clrEn | input | 1 | Strobe that clears sticky bits |
| clrMask | input | 4 | Sticky bits to clear when clrEn is high |
| result | output | 32 | Registered lane results |
| laneFlags | output | 4 | Registered per-lane overflow flags |
| stickyFlags | output | 4 | Accumulated overflow flags |
| resultValid | output | 1 | High the cycle after an accepted operation |

## Verification
The bound checker watches several properties on every cycle. It checks that `resultValid` follows `opValid` by one cycle, that `result` stays still when idle, and that the upper flags are zero after halfword operations. It checks that sticky bits never drop without a clear, and that they always cover the flags just produced. It also checks that a flagged lane after a clamping operation holds one of its limit values. The correct lane arithmetic itself can only be shown by the bench. Its sweeps compare every lane against an integer model across the sign, carry and limit boundaries in all eight operations. The clear-versus-set ordering is also shown only by the bench scenarios.

// File: rtl/simd_pkg.sv
`timescale 1ns/1ps
package simd_pkg;

  typedef enum logic [2:0] {
    OP_HADD    = 3'b000,
    OP_HADD_S  = 3'b001,
    OP_HSUB    = 3'b010,
    OP_HSUB_S  = 3'b011,
    OP_BADD    = 3'b100,
    OP_BADD_S  = 3'b101,
    OP_BSUB    = 3'b110,
    OP_BSUB_S  = 3'b111
  } opcode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // register a new result this cycle
    logic isByte;    // four unsigned bytes instead of two signed halves
    logic isSub;     // subtract srcB from srcA
    logic isSat;     // clamp instead of wrap
  } alu_ctrl_t;

endpackage

// File: rtl/simd_ctrl.sv
`timescale 1ns/1ps
module simd_ctrl
  import simd_pkg::*;
#(
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic              clrEn,
  input  logic [FLAG_W-1:0] clrMask,
  input  logic [FLAG_W-1:0] newFlags,
  output alu_ctrl_t         ctrl,
  output logic [FLAG_W-1:0] stickyFlags,
  output logic              resultValid
);

  opcode_e op;
  logic [FLAG_W-1:0] clearBits;
  logic [FLAG_W-1:0] setBits;

  assign op = opcode_e'(opCode);

  always_comb begin
    ctrl.capture = opValid;
    ctrl.isByte  = (op inside {OP_BADD, OP_BADD_S, OP_BSUB, OP_BSUB_S});
    ctrl.isSub   = (op inside {OP_HSUB, OP_HSUB_S, OP_BSUB, OP_BSUB_S});
    ctrl.isSat   = (op inside {OP_HADD_S, OP_HSUB_S, OP_BADD_S, OP_BSUB_S});
  end

  assign clearBits = clrEn ? clrMask : '0;
  assign setBits   = opValid ? newFlags : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stickyFlags <= '0;
      resultValid <= 1'b0;
    end else begin
      // setting wins over clearing on the same bit
      stickyFlags <= (stickyFlags & ~clearBits) | setBits;
      resultValid <= opValid;
    end
  end

endmodule

// File: rtl/simd_datapath.sv
`timescale 1ns/1ps
module simd_datapath
  import simd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = DATA_W / 2,
  localparam int NUM_BYTES  = DATA_W / BYTE_W,
  localparam int NUM_HALVES = DATA_W / HALF_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  alu_ctrl_t            ctrl,
  input  logic [DATA_W-1:0]    srcA,
  input  logic [DATA_W-1:0]    srcB,
  output logic [NUM_BYTES-1:0] nextFlags,
  output logic [DATA_W-1:0]    result,
  output logic [NUM_BYTES-1:0] laneFlags
);

  logic [DATA_W-1:0]     halfRes;
  logic [NUM_HALVES-1:0] halfOvf;
  logic [DATA_W-1:0]     byteRes;
  logic [NUM_BYTES-1:0]  byteOvf;
  logic [DATA_W-1:0]     nextResult;

  // Signed halfword lanes: invert-and-increment subtract, sign-rule overflow
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [HALF_W-1:0] aLane, bLane, bEff, sumLane, satVal;
    logic              ovf;
    assign aLane   = srcA[h*HALF_W +: HALF_W];
    assign bLane   = srcB[h*HALF_W +: HALF_W];
    assign bEff    = ctrl.isSub ? ~bLane : bLane;
    assign sumLane = aLane + bEff + {{(HALF_W-1){1'b0}}, ctrl.isSub};
    assign ovf     = (aLane[HALF_W-1] == bEff[HALF_W-1]) &&
                     (sumLane[HALF_W-1] != aLane[HALF_W-1]);
    assign satVal  = aLane[HALF_W-1] ? {1'b1, {(HALF_W-1){1'b0}}}
                                     : {1'b0, {(HALF_W-1){1'b1}}};
    assign halfRes[h*HALF_W +: HALF_W] = (ovf && ctrl.isSat) ? satVal : sumLane;
    assign halfOvf[h] = ovf;
  end

  // Unsigned byte lanes: one extra bit holds carry or borrow
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] aLane, bLane, satVal;
    logic [BYTE_W:0]   ext;
    assign aLane  = srcA[b*BYTE_W +: BYTE_W];
    assign bLane  = srcB[b*BYTE_W +: BYTE_W];
    assign ext    = ctrl.isSub ? ({1'b0, aLane} - {1'b0, bLane})
                               : ({1'b0, aLane} + {1'b0, bLane});
    assign satVal = ctrl.isSub ? {BYTE_W{1'b0}} : {BYTE_W{1'b1}};
    assign byteRes[b*BYTE_W +: BYTE_W] = (ext[BYTE_W] && ctrl.isSat) ? satVal
                                                                    : ext[BYTE_W-1:0];
    assign byteOvf[b] = ext[BYTE_W];
  end

  always_comb begin
    nextResult = ctrl.isByte ? byteRes : halfRes;
    nextFlags  = '0;
    if (ctrl.isByte) nextFlags = byteOvf;
    else             nextFlags[NUM_HALVES-1:0] = halfOvf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result    <= '0;
      laneFlags <= '0;
    end else if (ctrl.capture) begin
      result    <= nextResult;
      laneFlags <= nextFlags;
    end
  end

endmodule

// File: rtl/simd_sat_alu.sv
`timescale 1ns/1ps
module simd_sat_alu
  import simd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int FLAG_W = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic              clrEn,
  input  logic [FLAG_W-1:0] clrMask,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] laneFlags,
  output logic [FLAG_W-1:0] stickyFlags,
  output logic              resultValid
);

  alu_ctrl_t         ctrl;
  logic [FLAG_W-1:0] nextFlags;

  simd_ctrl #(.FLAG_W(FLAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .clrEn(clrEn), .clrMask(clrMask), .newFlags(nextFlags),
    .ctrl(ctrl), .stickyFlags(stickyFlags), .resultValid(resultValid)
  );

  simd_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .srcA(srcA), .srcB(srcB),
    .nextFlags(nextFlags), .result(result), .laneFlags(laneFlags)
  );

endmodule

// File: rtl/simd_sat_alu_chk.sv
`timescale 1ns/1ps
module simd_sat_alu_chk (
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [2:0]  opCode,
  input logic        clrEn,
  input logic [31:0] result,
  input logic [3:0]  laneFlags,
  input logic [3:0]  stickyFlags,
  input logic        resultValid
);

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resultValid);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!resultValid && $stable(result) && $stable(laneFlags)));

  // R4
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opCode[2]) |=> (laneFlags[3:2] == 2'b00));

  // R9
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrEn |=> ((stickyFlags & $past(stickyFlags)) == $past(stickyFlags)));

  // R9
  sticky_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> ((stickyFlags & laneFlags) == laneFlags));

  // R5
  half_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode[2:0] inside {3'b001, 3'b011}) |=>
      ((!laneFlags[1] || result[31:16] inside {16'h7FFF, 16'h8000}) &&
       (!laneFlags[0] || result[15:0]  inside {16'h7FFF, 16'h8000})));

  // R7
  byte_add_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'b101) |=>
      ((!laneFlags[0] || result[7:0] == 8'hFF) && (!laneFlags[3] || result[31:24] == 8'hFF)));

  // R7
  byte_sub_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'b111) |=>
      ((!laneFlags[0] || result[7:0] == 8'h00) && (!laneFlags[3] || result[31:24] == 8'h00)));

endmodule

bind simd_sat_alu simd_sat_alu_chk u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .clrEn(clrEn),
  .result(result), .laneFlags(laneFlags), .stickyFlags(stickyFlags),
  .resultValid(resultValid)
);

// File: tb/tb_simd_sat_alu.sv
`timescale 1ns/1ps
module tb_simd_sat_alu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [31:0] srcA = '0, srcB = '0;
  logic        clrEn = 1'b0;
  logic [3:0]  clrMask = '0;
  logic [31:0] result;
  logic [3:0]  laneFlags, stickyFlags;
  logic        resultValid;

  int testCount = 0;
  int failCount = 0;
  logic [3:0] expSticky = '0;

  always #2 clk = ~clk;   // 250 MHz

  simd_sat_alu dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .clrEn(clrEn), .clrMask(clrMask),
    .result(result), .laneFlags(laneFlags), .stickyFlags(stickyFlags),
    .resultValid(resultValid)
  );

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'b000, 3'b010: return "R3/R4";
      3'b001, 3'b011: return "R5";
      3'b100, 3'b110: return "R6";
      default:        return "R7";
    endcase
  endfunction

  // Integer model of one operation
  function automatic void model(input logic [2:0] op, input logic [31:0] a,
                                input logic [31:0] b, output logic [31:0] res,
                                output logic [3:0] flg);
    res = '0; flg = '0;
    if (!op[2]) begin
      for (int h = 0; h < 2; h++) begin
        int sa, sb, r;
        sa = $signed(a[h*16 +: 16]);
        sb = $signed(b[h*16 +: 16]);
        r  = op[1] ? sa - sb : sa + sb;
        flg[h] = (r > 32767) || (r < -32768);
        if (op[0] && r > 32767)  r = 32767;
        if (op[0] && r < -32768) r = -32768;
        res[h*16 +: 16] = r[15:0];
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        int r;
        r = op[1] ? int'(a[i*8 +: 8]) - int'(b[i*8 +: 8])
                  : int'(a[i*8 +: 8]) + int'(b[i*8 +: 8]);
        flg[i] = (r > 255) || (r < 0);
        if (op[0] && r > 255) r = 255;
        if (op[0] && r < 0)   r = 0;
        res[i*8 +: 8] = r[7:0];
      end
    end
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] eRes; logic [3:0] eFlg;
    model(op, a, b, eRes, eFlg);
    @(negedge clk);
    opValid = 1'b1; opCode = op; srcA = a; srcB = b;
    @(negedge clk);
    opValid = 1'b0;
    expSticky = expSticky | eFlg;
    check(result == eRes && laneFlags == eFlg, reqOf(op),
          {result, 28'd0, laneFlags}, {eRes, 28'd0, eFlg});
    check(resultValid == 1'b1, "R8", {63'd0, resultValid}, 64'd1);
    check(stickyFlags == expSticky, "R9", {60'd0, stickyFlags}, {60'd0, expSticky});
  endtask

  logic [15:0] hv [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                          16'hFFFF, 16'h7FFE, 16'h8001, 16'h1234};

  initial begin
    #200000;
    failCount++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(result == 0 && laneFlags == 0 && stickyFlags == 0 && resultValid == 0,
          "R1", {result, 20'd0, laneFlags, stickyFlags, 3'd0, resultValid}, 64'd0);
    rstN = 1'b1;

    // R2 R3 R4 R5: halfword boundary sweep over every opcode
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          runOp(op[2:0], {hv[i], hv[j]}, {hv[j], hv[i]});

    // R6 R7: near-exhaustive byte sweep, distinct pattern per lane
    for (int op = 4; op < 8; op++)
      for (int x = 0; x < 256; x += 7)
        for (int y = 0; y < 256; y += 3) begin
          logic [7:0] xb, yb;
          xb = x[7:0]; yb = y[7:0];
          runOp(op[2:0], {xb, xb ^ 8'h5A, ~xb, xb + 8'd1},
                         {yb, ~yb, yb ^ 8'hC3, yb + 8'd2});
        end

    // R3: carry must not pass between halves (low half FFFF+1)
    runOp(3'b000, 32'h0000FFFF, 32'h00000001);
    check(result == 32'h00000000, "R3", {32'd0, result}, 64'd0);

    // R8: idle cycle holds outputs, resultValid low
    begin
      logic [31:0] held; logic [3:0] heldF;
      held = result; heldF = laneFlags;
      @(negedge clk);
      check(result == held && laneFlags == heldF && !resultValid, "R8",
            {result, 28'd0, laneFlags}, {held, 28'd0, heldF});
    end

    // R9: partial clear
    @(negedge clk); clrEn = 1'b1; clrMask = 4'b0101;
    @(negedge clk); clrEn = 1'b0;
    expSticky = expSticky & ~4'b0101;
    check(stickyFlags == expSticky, "R9", {60'd0, stickyFlags}, {60'd0, expSticky});
    // R9: full clear
    @(negedge clk); clrEn = 1'b1; clrMask = 4'b1111;
    @(negedge clk); clrEn = 1'b0; expSticky = '0;
    check(stickyFlags == 4'b0000, "R9", {60'd0, stickyFlags}, 64'd0);
    // R9: clear with no op does nothing to an empty vector; set and clear together -> set wins
    @(negedge clk);
    opValid = 1'b1; opCode = 3'b101; srcA = 32'hFF00FF00; srcB = 32'h01000100;
    clrEn = 1'b1; clrMask = 4'b1111;
    @(negedge clk);
    opValid = 1'b0; clrEn = 1'b0;
    check(stickyFlags == 4'b1010, "R9", {60'd0, stickyFlags}, 64'b1010);
    check(result == 32'hFF01FF01 - 32'h00010001 + 32'h0, "R7",
          {32'd0, result}, {32'd0, 32'hFF00FF00});
    // R9: sticky holds without clear
    repeat (3) @(negedge clk);
    check(stickyFlags == 4'b1010, "R9", {60'd0, stickyFlags}, 64'b1010);

    // R1: reset again in mid-run
    rstN = 1'b0;
    @(negedge clk);
    check(result == 0 && laneFlags == 0 && stickyFlags == 0 && resultValid == 0,
          "R1", {result, 20'd0, laneFlags, stickyFlags, 3'd0, resultValid}, 64'd0);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule